// File: doc/BRIEF.md
# Branch Target and Direction Predictor

This block sits beside the fetch stage. It holds a small direct-mapped table. Each slot records the full address of a branch seen recently, the address that branch last jumped to, and a direction history. Every cycle the fetch address selects one slot through its low-order word-address bits. If the slot is valid and its stored address equals the fetch address exactly, the history decides the next fetch address. A taken prediction supplies the stored target. A not-taken prediction, and any miss, supplies the fetch address plus four.

When a branch resolves later in the pipeline, the resolving stage drives the update port with the branch address, its real outcome and its real target. The slot chosen by that address is handled in one of two ways. If it already tracks the same branch, its history steps and its target is refreshed. Otherwise the slot is taken over by the new branch.

A parameter selects a two-bit saturating history or a one-bit last-outcome history.

Top module: `brpred_table`

## Requirements
- R1: The slot is selected by `fetch_pc[IDX_W+1:2]` for lookup and by `upd_pc[IDX_W+1:2]` for update. Branches at different slots are kept independently.
- R2: After reset every slot is invalid, so every lookup misses: `pred_hit`=0, `pred_taken`=0 and `pred_next_pc`=`fetch_pc`+4.
- R3: A hit needs the stored branch address to equal the whole `fetch_pc`. An address that selects an occupied slot but differs from its stored address misses.
- R4: On a hit predicted taken, `pred_next_pc` is the stored target. On a hit predicted not taken, or on a miss, it is `fetch_pc`+4. `pred_taken` is never 1 without `pred_hit`.
- R5: In two-bit mode the history encodings 2'b11 and 2'b10 predict taken, and 2'b01 and 2'b00 predict not taken.
- R6: In two-bit mode an update to a tracked branch moves the history one step up on taken and one step down on not taken. It saturates at 2'b11 and at 2'b00.
- R7: In two-bit mode, from the strongly-taken state one not-taken outcome leaves the prediction taken. A second consecutive not-taken outcome turns it to not taken.
- R8: An update whose address does not match the slot's valid stored address takes over the slot. It stores the new address and target, and it stores history 2'b10 in two-bit mode or the outcome in one-bit mode. The previous occupant then misses.
- R9: An update to a tracked branch replaces its stored target with the one supplied.
- R10: In one-bit mode the prediction equals the outcome of the most recent update to that branch.
- R11: A lookup in the same cycle as an update to the same slot returns the slot's old contents. The new contents show from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | Lookup found the fetch address in the table |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
The bench builds two copies side by side, both with a 32-bit address and `IDX_W`=3. One copy uses `HIST_BITS`=2 and the other `HIST_BITS`=1, and every update goes to both. The 8-slot table lets two short addresses, 0x40 and 0x60, fall on the same slot, which makes aliasing and slot takeover easy to reach. One shared update sequence walks the two-bit history through every state, including both saturation points. On the one-bit copy, the same sequence shows the prediction flipping after every change of outcome.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        HIST_STRONG_NT = 2'b00,
        HIST_WEAK_NT   = 2'b01,
        HIST_WEAK_TK   = 2'b10,
        HIST_STRONG_TK = 2'b11
    } hist_e;

    // saturating up/down step of the two-bit history
    function automatic logic [1:0] hist_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == HIST_STRONG_TK) ? cur : cur + 2'd1;
        else       nxt = (cur == HIST_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_hist_update.sv
module bp_hist_update
    import bp_pkg::*;
#(
    parameter int HIST_BITS = 2
) (
    input  logic [1:0] hist_cur,
    input  logic       same_branch,
    input  logic       taken,
    output logic [1:0] hist_new,
    input  logic [1:0] hist_look,
    output logic       look_taken
);

    // history is kept as two bits; the MSB is always the direction
    assign look_taken = hist_look[1];

    generate
        if (HIST_BITS == 1) begin : g_one_bit
            always_comb begin
                hist_new = {taken, 1'b0};
            end
        end else begin : g_two_bit
            always_comb begin
                if (same_branch) hist_new = hist_step(hist_cur, taken);
                else             hist_new = HIST_WEAK_TK;
            end
        end
    endgenerate

endmodule

// File: rtl/bp_table.sv
module bp_table #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_addr,
    output logic [PC_W-1:0]  rd_target,
    output logic [1:0]       rd_hist,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_valid,
    output logic [PC_W-1:0]  up_addr,
    output logic [1:0]       up_hist,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_addr,
    input  logic [PC_W-1:0]  wr_target,
    input  logic [1:0]       wr_hist
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q, valid_d;
    logic [PC_W-1:0]  addr_q   [DEPTH], addr_d   [DEPTH];
    logic [PC_W-1:0]  target_q [DEPTH], target_d [DEPTH];
    logic [1:0]       hist_q   [DEPTH], hist_d   [DEPTH];

    assign rd_valid  = valid_q[rd_idx];
    assign rd_addr   = addr_q[rd_idx];
    assign rd_target = target_q[rd_idx];
    assign rd_hist   = hist_q[rd_idx];
    assign up_valid  = valid_q[up_idx];
    assign up_addr   = addr_q[up_idx];
    assign up_hist   = hist_q[up_idx];

    always_comb begin
        valid_d  = valid_q;
        addr_d   = addr_q;
        target_d = target_q;
        hist_d   = hist_q;
        if (wr_en) begin
            valid_d[up_idx]  = 1'b1;
            addr_d[up_idx]   = wr_addr;
            target_d[up_idx] = wr_target;
            hist_d[up_idx]   = wr_hist;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
        addr_q   <= addr_d;
        target_q <= target_d;
        hist_q   <= hist_d;
    end

    // R2: the first cycle out of reset sees an empty table
    a_r2_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    // R11: a write lands in its slot by the next cycle, with the written history
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(up_idx)] && hist_q[$past(up_idx)] == $past(wr_hist)));

endmodule

// File: rtl/brpred_table.sv
module brpred_table
    import bp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 4,
    parameter int HIST_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_next_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] look_idx, upd_idx;
    logic             look_valid, up_valid;
    logic [PC_W-1:0]  look_addr, look_target, up_addr;
    logic [1:0]       look_hist, up_hist, hist_new;
    logic             look_dir, upd_match;

    assign look_idx  = fetch_pc[IDX_HI:IDX_LO];
    assign upd_idx   = upd_pc[IDX_HI:IDX_LO];
    assign upd_match = up_valid && (up_addr == upd_pc);

    bp_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (look_idx),
        .rd_valid  (look_valid),
        .rd_addr   (look_addr),
        .rd_target (look_target),
        .rd_hist   (look_hist),
        .up_idx    (upd_idx),
        .up_valid  (up_valid),
        .up_addr   (up_addr),
        .up_hist   (up_hist),
        .wr_en     (upd_valid),
        .wr_addr   (upd_pc),
        .wr_target (upd_target),
        .wr_hist   (hist_new)
    );

    bp_hist_update #(.HIST_BITS(HIST_BITS)) u_hist (
        .hist_cur    (up_hist),
        .same_branch (upd_match),
        .taken       (upd_taken),
        .hist_new    (hist_new),
        .hist_look   (look_hist),
        .look_taken  (look_dir)
    );

    always_comb begin
        pred_hit     = look_valid && (look_addr == fetch_pc);
        pred_taken   = pred_hit && look_dir;
        pred_next_pc = pred_taken ? look_target : fetch_pc + PC_W'(4);
    end

    // R4: no taken prediction without a tag hit
    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R7: one not-taken outcome from strongly taken keeps the taken direction
    a_r7_strong_survives_one_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (HIST_BITS == 2 && upd_valid && upd_match && up_hist == HIST_STRONG_TK)
        |-> hist_new[1]);

    // R6: the bottom state saturates on a not-taken outcome
    a_r6_floor_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (HIST_BITS == 2 && upd_valid && upd_match && up_hist == HIST_STRONG_NT && !upd_taken)
        |-> hist_new == HIST_STRONG_NT);

    // R8: a takeover starts weakly taken (two-bit) or at the outcome (one-bit)
    a_r8_takeover_state: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_match)
        |-> hist_new == ((HIST_BITS == 2) ? HIST_WEAK_TK : {upd_taken, 1'b0}));

endmodule

// File: tb/brpred_table_bench.sv
`timescale 1ns/1ps
module brpred_table_bench;

    localparam int PW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fetch_pc = '0;
    logic          upd_valid = 1'b0;
    logic [PW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [PW-1:0] upd_target = '0;

    logic [PW-1:0] n2_next, n1_next;
    logic          h2_hit, h1_hit, t2_tk, t1_tk;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    brpred_table #(.PC_W(PW), .IDX_W(IW), .HIST_BITS(2)) u_brpred_table (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_next_pc(n2_next), .pred_hit(h2_hit), .pred_taken(t2_tk),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target));

    brpred_table #(.PC_W(PW), .IDX_W(IW), .HIST_BITS(1)) u_brpred_table_h1 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_next_pc(n1_next), .pred_hit(h1_hit), .pred_taken(t1_tk),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target));

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // look up pc; check both copies: {hit, taken, next}
    task automatic look(input string req, input logic [PW-1:0] pc,
                        input logic hit2, input logic tk2, input logic [PW-1:0] nx2,
                        input logic hit1, input logic tk1, input logic [PW-1:0] nx1);
        @(negedge clk);
        fetch_pc = pc;
        #0.5;
        chk({req, " two-bit hit"},   PW'(h2_hit), PW'(hit2));
        chk({req, " two-bit taken"}, PW'(t2_tk),  PW'(tk2));
        chk({req, " two-bit next"},  n2_next,     nx2);
        chk({req, " one-bit hit"},   PW'(h1_hit), PW'(hit1));
        chk({req, " one-bit taken"}, PW'(t1_tk),  PW'(tk1));
        chk({req, " one-bit next"},  n1_next,     nx1);
    endtask

    task automatic resolve(input logic [PW-1:0] pc, input logic tk, input logic [PW-1:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
        @(negedge clk);
        upd_valid  = 1'b0;
    endtask

    localparam logic [PW-1:0] PC_A = 32'h40;  // slot 0
    localparam logic [PW-1:0] PC_B = 32'h60;  // slot 0, aliases A
    localparam logic [PW-1:0] PC_C = 32'h44;  // slot 1
    localparam logic [PW-1:0] TG_A = 32'h800;

    task automatic t_reset;
        look("R2 empty", 32'h100, 0, 0, 32'h104, 0, 0, 32'h104);
        look("R2 empty A", PC_A, 0, 0, PC_A + 4, 0, 0, PC_A + 4);
    endtask

    task automatic t_alloc;
        resolve(PC_A, 1'b1, TG_A);
        look("R8 R5 R4 takeover", PC_A, 1, 1, TG_A, 1, 1, TG_A);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc = PC_C; upd_valid = 1'b1; upd_pc = PC_C; upd_taken = 1'b1; upd_target = 32'hA00;
        #0.5;
        chk("R11 old contents two-bit", PW'(h2_hit), 0);
        chk("R11 old contents one-bit", n1_next, PC_C + 4);
        @(negedge clk);
        upd_valid = 1'b0;
        #0.5;
        chk("R11 new contents two-bit", n2_next, 32'hA00);
        chk("R11 new contents one-bit", n1_next, 32'hA00);
    endtask

    task automatic t_history;
        resolve(PC_A, 1'b1, TG_A);   // 10->11, 1b taken
        look("R6 up to strong", PC_A, 1, 1, TG_A, 1, 1, TG_A);
        resolve(PC_A, 1'b0, TG_A);   // 11->10 still taken; 1b flips
        look("R7 R10 first miss", PC_A, 1, 1, TG_A, 1, 0, PC_A + 4);
        resolve(PC_A, 1'b0, TG_A);   // 10->01
        look("R7 second miss", PC_A, 1, 0, PC_A + 4, 1, 0, PC_A + 4);
        resolve(PC_A, 1'b0, TG_A);   // 01->00
        resolve(PC_A, 1'b0, TG_A);   // 00 stays
        look("R6 floor", PC_A, 1, 0, PC_A + 4, 1, 0, PC_A + 4);
        resolve(PC_A, 1'b1, TG_A);   // 00->01 not taken; 1b taken
        look("R6 R10 one up from floor", PC_A, 1, 0, PC_A + 4, 1, 1, TG_A);
        resolve(PC_A, 1'b1, TG_A);   // 01->10 taken
        look("R5 weak taken", PC_A, 1, 1, TG_A, 1, 1, TG_A);
    endtask

    task automatic t_alias;
        look("R3 alias miss", PC_B, 0, 0, PC_B + 4, 0, 0, PC_B + 4);
        resolve(PC_B, 1'b0, 32'hB00);
        look("R8 alias takeover", PC_B, 1, 1, 32'hB00, 1, 0, PC_B + 4);
        look("R8 R3 old occupant", PC_A, 0, 0, PC_A + 4, 0, 0, PC_A + 4);
        look("R1 other slot kept", PC_C, 1, 1, 32'hA00, 1, 1, 32'hA00);
    endtask

    task automatic t_retarget;
        resolve(PC_B, 1'b1, 32'hC00);
        look("R9 new target", PC_B, 1, 1, 32'hC00, 1, 1, 32'hC00);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_same_cycle();
        t_history();
        t_alias();
        t_retarget();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule